// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column address for each beat of a synchronous DRAM read or write burst. A mode load stores the burst length, the wrap order (sequential or interleaved) and a single-write option. A read or write command captures a start column. From the clock edge that samples the command, the block presents one column per rising edge until the burst ends. The burst ends when its beats run out, when a terminate command arrives, or when a new read or write replaces it.

The block sits beside the command path of a memory controller. The controller sends it the same strobes it sends the memory, and it uses `col`, `busy` and `last` to step its data path. Length and wrap order are latched when a command is accepted, so the running burst keeps its shape even if the mode is written again.

Top module: `sdram_burst_colseq`

## Requirements
- R1: After reset, `busy`, `last` and `mode_err` are 0 and `col` is 0. The mode is length 1, sequential, with single-write off, so a read issued without any mode load gives exactly one beat.
- R2: `mode_len` codes are 0 = 1 beat, 1 = 2, 2 = 4, 3 = 8 and 7 = full page. `mode_ilv` = 0 selects sequential order. A sequential burst of length BL from start S gives `col` = (S with its low log2(BL) bits replaced by (S + k) mod BL) on beat k.
- R3: `mode_ilv` = 1 selects interleaved order. On beat k, `col` equals S XOR k, where k < BL.
- R4: A command sampled at edge t makes `busy` 1 from edge t through edge t+BL-1, with beat k visible after edge t+k. `last` is 1 only on beat BL-1. `busy` falls at edge t+BL unless a new command arrives there.
- R5: In full page mode `col` counts up by one per edge over all 8 column bits, wrapping from 255 to 0. `last` stays 0, and the burst runs until it is terminated or replaced.
- R6: `cmd_bst` without `cmd_rd` or `cmd_wr` ends a burst at the edge that samples it: `busy` and `last` are 0 and `col` is 0 after that edge. When idle it has no effect.
- R7: A read or write sampled during a burst restarts at beat 0 from its own start column on the next beat, with no idle cycle. If `cmd_bst` is sampled at the same edge, the read or write wins.
- R8: With `mode_bsw` = 1, every write is one beat and reads keep the programmed length.
- R9: A mode load of full page with interleave, or of a code from 4 to 6, sets `mode_err` and stores length 8, keeping the requested wrap order. A legal load clears `mode_err`.
- R10: A burst uses the mode held when its command was sampled. A mode load at the same edge as the command, or during the burst, affects only later commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Load the mode fields below |
| mode_len | input | 3 | Burst length code |
| mode_ilv | input | 1 | 1 = interleaved wrap order |
| mode_bsw | input | 1 | 1 = writes are single beat |
| cmd_rd | input | 1 | Read command strobe |
| cmd_wr | input | 1 | Write command strobe |
| cmd_bst | input | 1 | Burst terminate strobe |
| start_col | input | COL_W | Start column for a read or write |
| col | output | COL_W | Column of the current beat, 0 when idle |
| busy | output | 1 | A burst beat is being presented |
| last | output | 1 | Current beat is the final one of a fixed-length burst |
| mode_err | output | 1 | Last mode load was illegal and was replaced by length 8 |

## Verification
Every output is due one edge after the command, terminate or mode load that causes it. Beat k of a burst is due k edges after its command, and `busy` falls BL edges after the command. The bench drives inputs and samples outputs 5 ns after each rising edge, with nothing on the falling edge. Each reading therefore shows exactly the edges counted so far. Expected columns come from mod and XOR arithmetic on the start column and beat index. The sweep covers every start column for each fixed length in both orders.

// File: rtl/colseq_pkg.sv
package colseq_pkg;
   localparam logic [2:0] LEN_1    = 3'd0;
   localparam logic [2:0] LEN_2    = 3'd1;
   localparam logic [2:0] LEN_4    = 3'd2;
   localparam logic [2:0] LEN_8    = 3'd3;
   localparam logic [2:0] LEN_FULL = 3'd7;

   typedef struct packed {
      logic [2:0] len;
      logic       ilv;
      logic       bsw;
   } colseq_mode_t;

   function automatic logic len_code_illegal(input logic [2:0] code, input logic ilv);
      return (code == LEN_FULL && ilv) || (code > LEN_8 && code != LEN_FULL);
   endfunction
endpackage

// File: rtl/colseq_mode_reg.sv
module colseq_mode_reg
   import colseq_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [2:0]   len_in,
   input  logic         ilv_in,
   input  logic         bsw_in,
   output colseq_mode_t mode,
   output logic         err
);
   colseq_mode_t next_mode;
   logic         bad;

   always_comb begin
      bad            = len_code_illegal(len_in, ilv_in);
      next_mode.len  = bad ? LEN_8 : len_in;
      next_mode.ilv  = ilv_in;
      next_mode.bsw  = bsw_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= '{len: LEN_1, ilv: 1'b0, bsw: 1'b0};
         err  <= 1'b0;
      end else if (wr) begin
         mode <= next_mode;
         err  <= bad;
      end
   end
endmodule

// File: rtl/colseq_beat_ctrl.sv
module colseq_beat_ctrl
   import colseq_pkg::*;
#(
   parameter int COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  colseq_mode_t     mode,
   input  logic             cmd_rd,
   input  logic             cmd_wr,
   input  logic             cmd_bst,
   input  logic [COL_W-1:0] start_col,
   output logic             busy,
   output logic [COL_W-1:0] cnt,
   output logic [COL_W-1:0] base,
   output logic [COL_W-1:0] mask,
   output logic             ilv,
   output logic             last
);
   logic             full;
   logic             accept;
   logic             single;
   logic [COL_W-1:0] new_mask;
   logic             new_full;

   assign accept = cmd_rd | cmd_wr;
   assign single = cmd_wr & ~cmd_rd & mode.bsw;

   always_comb begin
      new_full = 1'b0;
      case (mode.len)
         LEN_1:   new_mask = '0;
         LEN_2:   new_mask = COL_W'(1);
         LEN_4:   new_mask = COL_W'(3);
         LEN_8:   new_mask = COL_W'(7);
         default: begin
            new_mask = '1;
            new_full = 1'b1;
         end
      endcase
      if (single) begin
         new_mask = '0;
         new_full = 1'b0;
      end
   end

   assign last = busy & ~full & (cnt == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
         base <= '0;
         mask <= '0;
         ilv  <= 1'b0;
         full <= 1'b0;
      end else if (accept) begin
         busy <= 1'b1;
         cnt  <= '0;
         base <= start_col;
         mask <= new_mask;
         ilv  <= mode.ilv;
         full <= new_full;
      end else if (cmd_bst || last) begin
         busy <= 1'b0;
      end else if (busy) begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/colseq_addr_gen.sv
module colseq_addr_gen #(
   parameter int COL_W = 8
) (
   input  logic             busy,
   input  logic [COL_W-1:0] base,
   input  logic [COL_W-1:0] cnt,
   input  logic [COL_W-1:0] mask,
   input  logic             ilv,
   output logic [COL_W-1:0] col
);
   logic [COL_W-1:0] sum;
   assign sum = base + cnt;

   for (genvar i = 0; i < COL_W; i++) begin : g_bit
      logic wrapped;
      assign wrapped = ilv ? (base[i] ^ cnt[i]) : sum[i];
      assign col[i]  = busy & (mask[i] ? wrapped : base[i]);
   end
endmodule

// File: rtl/sdram_burst_colseq.sv
module sdram_burst_colseq
   import colseq_pkg::*;
#(
   parameter int COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_wr,
   input  logic [2:0]       mode_len,
   input  logic             mode_ilv,
   input  logic             mode_bsw,
   input  logic             cmd_rd,
   input  logic             cmd_wr,
   input  logic             cmd_bst,
   input  logic [COL_W-1:0] start_col,
   output logic [COL_W-1:0] col,
   output logic             busy,
   output logic             last,
   output logic             mode_err
);
   if (COL_W < 3 || COL_W > 16) begin : g_bad_width
      $error("COL_W must lie between 3 and 16");
   end

   colseq_mode_t     mode;
   logic [COL_W-1:0] cnt, base, mask;
   logic             ilv;

   colseq_mode_reg u_mode (
      .clk(clk), .rst_n(rst_n), .wr(mode_wr), .len_in(mode_len),
      .ilv_in(mode_ilv), .bsw_in(mode_bsw), .mode(mode), .err(mode_err)
   );

   colseq_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .mode(mode), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
      .cmd_bst(cmd_bst), .start_col(start_col), .busy(busy), .cnt(cnt),
      .base(base), .mask(mask), .ilv(ilv), .last(last)
   );

   colseq_addr_gen #(.COL_W(COL_W)) u_addr (
      .busy(busy), .base(base), .cnt(cnt), .mask(mask), .ilv(ilv), .col(col)
   );
endmodule

// File: rtl/colseq_checker.sv
module colseq_checker #(
   parameter int COL_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mode_wr,
   input logic [2:0]       mode_len,
   input logic             mode_ilv,
   input logic             cmd_rd,
   input logic             cmd_wr,
   input logic             cmd_bst,
   input logic [COL_W-1:0] start_col,
   input logic [COL_W-1:0] col,
   input logic             busy,
   input logic             last,
   input logic             mode_err
);
   // R4
   last_has_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last |-> busy);

   // R4
   end_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last && !cmd_rd && !cmd_wr) |=> !busy);

   // R4
   mid_burst_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last && !cmd_bst) |=> busy);

   // R6
   terminate_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_bst && !cmd_rd && !cmd_wr) |=> (!busy && !last && col == '0));

   // R7
   restart_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_rd || cmd_wr) |=> (busy && col == $past(start_col)));

   // R9
   illegal_mode_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr && mode_len == 3'd7 && mode_ilv) |=> mode_err);

   // R9
   legal_mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr && (mode_len < 3'd4 || (mode_len == 3'd7 && !mode_ilv))) |=> !mode_err);
endmodule

bind sdram_burst_colseq colseq_checker #(.COL_W(COL_W)) u_chk (.*);

// File: tb/sdram_burst_colseq_tb.sv
module sdram_burst_colseq_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_wr = 0, mode_ilv = 0, mode_bsw = 0;
   logic [2:0] mode_len = 0;
   logic       cmd_rd = 0, cmd_wr = 0, cmd_bst = 0;
   logic [7:0] start_col = 0;
   logic [7:0] col;
   logic       busy, last, mode_err;
   int         vectors = 0;
   int         errors = 0;
   bit         done = 0;

   always #10 clk = ~clk;

   sdram_burst_colseq #(.COL_W(8)) u_dut (.*);

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      #5;
   endtask

   function automatic logic [7:0] exp_col(input logic [7:0] s, input int k,
                                          input int bl, input bit ilv);
      logic [7:0] m;
      m = 8'(bl - 1);
      if (ilv) return s ^ 8'(k);
      return (s & ~m) | (8'(s + 8'(k)) & m);
   endfunction

   task automatic check_beat(input string req, input logic [7:0] e, input bit el);
      chk(busy === 1'b1, req, busy, 1);
      chk(col === e, req, col, e);
      chk(last === el, req, last, el);
   endtask

   task automatic check_idle(input string req);
      chk(busy === 1'b0, req, busy, 0);
      chk(col === 8'h00, req, col, 0);
      chk(last === 1'b0, req, last, 0);
   endtask

   task automatic load_mode(input logic [2:0] code, input bit ilv, input bit bsw);
      mode_wr = 1; mode_len = code; mode_ilv = ilv; mode_bsw = bsw;
      tick;
      mode_wr = 0;
   endtask

   // Issue a command and follow the burst to its end.
   task automatic burst(input string req, input bit wr, input logic [7:0] s,
                        input int bl, input bit ilv);
      cmd_rd = !wr; cmd_wr = wr; start_col = s;
      tick;
      cmd_rd = 0; cmd_wr = 0;
      for (int k = 0; k < bl; k++) begin
         check_beat(req, exp_col(s, k, bl, ilv), k == bl - 1);
         tick;
      end
      check_idle(req);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      #25 rst_n = 1;
      tick;
      // R1 reset state and default single-beat length
      check_idle("R1");
      chk(mode_err === 1'b0, "R1", mode_err, 0);
      burst("R1", 0, 8'h5a, 1, 0);

      // R2 / R3 / R4 sweep over all starts, fixed lengths, both orders
      for (int ilv = 0; ilv < 2; ilv++)
         for (int code = 0; code < 4; code++) begin
            load_mode(3'(code), ilv[0], 0);
            for (int s = 0; s < 256; s++)
               burst(ilv ? "R3" : "R2", s[0], 8'(s), 1 << code, ilv[0]);
         end

      // R5 full page wraps and runs until terminated
      load_mode(3'd7, 0, 0);
      chk(mode_err === 1'b0, "R5", mode_err, 0);
      cmd_rd = 1; start_col = 8'hfa;
      tick;
      cmd_rd = 0;
      for (int k = 0; k < 300; k++) begin
         check_beat("R5", 8'(8'hfa + k), 0);
         if (k == 299) cmd_bst = 1;
         tick;
      end
      cmd_bst = 0;
      check_idle("R6");

      // R6 terminate mid-burst, and terminate while idle
      load_mode(3'd3, 0, 0);
      cmd_rd = 1; start_col = 8'h33;
      tick;
      cmd_rd = 0;
      check_beat("R6", 8'h33, 0);
      tick;
      check_beat("R6", 8'h34, 0);
      cmd_bst = 1;
      tick;
      check_idle("R6");
      tick;
      cmd_bst = 0;
      check_idle("R6");

      // R7 interrupt with no gap, then rd beats bst at the same edge
      cmd_rd = 1; start_col = 8'h15;
      tick;
      cmd_rd = 0;
      check_beat("R7", 8'h15, 0);
      tick;
      check_beat("R7", 8'h16, 0);
      cmd_wr = 1; start_col = 8'h44;
      tick;
      cmd_wr = 0;
      check_beat("R7", 8'h44, 0);
      tick;
      check_beat("R7", 8'h45, 0);
      cmd_rd = 1; cmd_bst = 1; start_col = 8'h86;
      tick;
      cmd_rd = 0; cmd_bst = 0;
      for (int k = 0; k < 8; k++) begin
         check_beat("R7", exp_col(8'h86, k, 8, 0), k == 7);
         tick;
      end
      check_idle("R7");

      // R8 single-write mode
      load_mode(3'd2, 1, 1);
      burst("R8", 1, 8'h27, 1, 1);
      burst("R8", 0, 8'h27, 4, 1);

      // R9 illegal loads fall back to length 8
      load_mode(3'd7, 1, 0);
      chk(mode_err === 1'b1, "R9", mode_err, 1);
      burst("R9", 0, 8'h6b, 8, 1);
      load_mode(3'd5, 0, 0);
      chk(mode_err === 1'b1, "R9", mode_err, 1);
      burst("R9", 0, 8'h6b, 8, 0);
      load_mode(3'd1, 0, 0);
      chk(mode_err === 1'b0, "R9", mode_err, 0);
      burst("R9", 0, 8'h6b, 2, 0);

      // R10 mode loads at and after the command leave the burst alone
      load_mode(3'd3, 0, 0);
      cmd_rd = 1; start_col = 8'h1e;
      mode_wr = 1; mode_len = 3'd0; mode_ilv = 1;
      tick;
      cmd_rd = 0; mode_wr = 0;
      for (int k = 0; k < 8; k++) begin
         check_beat("R10", exp_col(8'h1e, k, 8, 0), k == 7);
         if (k == 3) begin mode_wr = 1; mode_len = 3'd2; mode_ilv = 0; end
         else mode_wr = 0;
         tick;
      end
      mode_wr = 0;
      check_idle("R10");
      burst("R10", 0, 8'h1e, 4, 0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule